// File: doc/BRIEF.md
# Coprocessor Instruction Queue Tracker

This block sits beside a host CPU and listens without driving anything. It keeps a shadow of the host's instruction prefetch queue. Bytes enter the shadow on the host's code-fetch bus cycles. Bytes leave it when the host's two queue-status lines report that the host consumed a byte. From this stream the block finds escape instructions meant for a coprocessor. For each one it produces a 6-bit coprocessor opcode and the addressing-mode fields of the second byte.

The host's bus width is learned while reset is held. A narrow host gets a 4-byte shadow that takes one byte per fetch. A wide host gets a 6-byte shadow that takes two bytes per fetch, low byte first. A flush status empties the shadow and abandons any half-decoded escape. Taking a byte from an empty shadow raises a sticky error flag.

Top module: `cpq_tracker`

## Requirements
- R1: While `rst_n` is low, `host_sel` is sampled: 0 selects a narrow host with a 4-byte shadow, 1 selects a wide host with a 6-byte shadow. The selection holds until the next reset, and `q_level` never exceeds the selected depth.
- R2: When `fetch_we` is high, a narrow host loads `fetch_data[7:0]` at the tail. A wide host loads `fetch_data[7:0]` and then `fetch_data[15:8]`. `q_head` shows the oldest byte and `q_level` shows the byte count, both updated at the clock edge.
- R3: A fetch whose bytes do not all fit after this cycle's removal is dropped as a whole, and the contents are left unchanged.
- R4: `qs` = 01 (first opcode byte) or 11 (later byte) removes the head byte. `qs` = 00 does nothing. A removal and a fetch in the same cycle are both applied, the removal first.
- R5: `qs` = 10 empties the shadow and cancels a pending escape. A fetch in the same cycle loads into the emptied shadow.
- R6: A byte taken with `qs` = 01 whose bits [7:3] are 11011 starts an escape. The next byte taken with `qs` = 11 completes it. After that edge `op_valid` is high for one cycle, with `op_code` = {escape[2:0], second[5:3]}, `op_mod` = second[7:6], `op_reg` = second[5:3] and `op_rm` = second[2:0].
- R7: A byte taken with `qs` = 01 that lacks the 11011 prefix is ignored, and bytes taken after it with `qs` = 11 give no `op_valid`.
- R8: A take code (01 or 11) while the shadow is empty sets `underflow_err`, which stays high until reset. That take removes nothing and decodes nothing.
- R9: After reset `q_level` is 0, and `op_valid` and `underflow_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host width sense, sampled during reset (1 = wide) |
| fetch_we | input | 1 | Host code-fetch cycle carries data |
| fetch_data | input | 16 | Fetched bytes, low byte oldest |
| qs | input | 2 | Host queue status |
| q_level | output | 3 | Bytes in the shadow |
| q_head | output | 8 | Oldest shadow byte |
| op_valid | output | 1 | One-cycle opcode strobe |
| op_code | output | 6 | Coprocessor opcode |
| op_mod | output | 2 | Mode field of the second byte |
| op_reg | output | 3 | Middle field of the second byte |
| op_rm | output | 3 | r/m field of the second byte |
| underflow_err | output | 1 | Sticky empty-take flag |

## Verification
Every result is registered once. Queue level, head byte, error flag and the opcode strobe all reflect the inputs of cycle N right after edge N, with no further delay. The bench drives each cycle's status and fetch at the falling edge. It advances its own queue model for that same cycle and compares every output 1 ns after the following rising edge, so each expectation lines up with exactly one edge. The strobe is checked low on every other cycle, which also confirms that it lasts one cycle.

// File: rtl/cpq_tracker.sv
module cpq_tracker #(
  parameter int DW   = 8,
  parameter int NDEP = 4,
  parameter int WDEP = 6,
  parameter logic [4:0] ESC = 5'b11011,
  localparam int MAXD = (WDEP > NDEP) ? WDEP : NDEP,
  localparam int LW   = $clog2(MAXD + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_sel,
  input  logic            fetch_we,
  input  logic [2*DW-1:0] fetch_data,
  input  logic [1:0]      qs,
  output logic [LW-1:0]   q_level,
  output logic [DW-1:0]   q_head,
  output logic            op_valid,
  output logic [5:0]      op_code,
  output logic [1:0]      op_mod,
  output logic [2:0]      op_reg,
  output logic [2:0]      op_rm,
  output logic            underflow_err
);
  logic          wide, pend;
  logic [2:0]    esc_lo;
  logic [LW-1:0] cnt;
  logic [DW-1:0] q  [MAXD];
  logic [DW-1:0] nq [MAXD];

  wire           flush = (qs == 2'b10);
  wire           take  = qs[0];
  wire           empty = (cnt == '0);
  wire           pop   = take && !empty && !flush;
  wire [LW-1:0]  depth = wide ? LW'(WDEP) : LW'(NDEP);
  wire [LW-1:0]  nin   = fetch_we ? (wide ? LW'(2) : LW'(1)) : '0;
  wire [LW-1:0]  base  = flush ? '0 : cnt - LW'(pop);
  wire           load  = fetch_we && ({1'b0, base} + {1'b0, nin} <= {1'b0, depth});
  wire [DW-1:0]  head  = q[0];

  assign q_level = cnt;
  assign q_head  = head;

  always_comb begin
    for (int i = 0; i < MAXD; i++) begin
      nq[i] = (pop && i < MAXD - 1) ? q[i+1] : q[i];
      if (load && i == int'(base)) nq[i] = fetch_data[DW-1:0];
      if (load && wide && i == int'(base) + 1) nq[i] = fetch_data[2*DW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAXD; i++) q[i] <= nq[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wide          <= host_sel;
      cnt           <= '0;
      pend          <= 1'b0;
      esc_lo        <= '0;
      op_valid      <= 1'b0;
      op_code       <= '0;
      op_mod        <= '0;
      op_reg        <= '0;
      op_rm         <= '0;
      underflow_err <= 1'b0;
    end else begin
      cnt      <= load ? base + nin : base;
      op_valid <= 1'b0;
      if (flush)
        pend <= 1'b0;
      else if (take && empty)
        underflow_err <= 1'b1;
      else if (qs == 2'b01) begin
        pend   <= (head[DW-1:DW-5] == ESC);
        esc_lo <= head[2:0];
      end else if (qs == 2'b11 && pend) begin
        pend     <= 1'b0;
        op_valid <= 1'b1;
        op_code  <= {esc_lo, head[5:3]};
        op_mod   <= head[7:6];
        op_reg   <= head[5:3];
        op_rm    <= head[2:0];
      end
    end
  end
endmodule

// File: rtl/cpq_tracker_chk.sv
module cpq_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wide,
  input logic [1:0] qs,
  input logic       fetch_we,
  input logic [2:0] q_level,
  input logic       op_valid,
  input logic       underflow_err
);
  // R1
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= (wide ? 3'd6 : 3'd4));
  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qs == 2'b10 && !fetch_we) |=> (q_level == 3'd0));
  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);
  // R6
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> $past(qs) == 2'b11);
  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
endmodule

bind cpq_tracker cpq_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wide(wide), .qs(qs), .fetch_we(fetch_we),
  .q_level(q_level), .op_valid(op_valid), .underflow_err(underflow_err)
);

// File: tb/tb_cpq_tracker.sv
`timescale 1ns/1ps
module tb_cpq_tracker;
  logic clk = 0, rst_n = 0, host_sel = 0, fetch_we = 0;
  logic [15:0] fetch_data = '0;
  logic [1:0] qs = '0;
  logic [2:0] q_level;
  logic [7:0] q_head;
  logic op_valid, underflow_err;
  logic [5:0] op_code;
  logic [1:0] op_mod;
  logic [2:0] op_reg, op_rm;

  int runs = 0, fails = 0;
  logic [7:0] eq [6];
  int ecnt;
  bit ewide, epend, eerr, evalid;
  logic [2:0] elo;
  logic [5:0] eop;
  logic [1:0] emod;
  logic [2:0] ereg, erm;

  always #2.5 clk = ~clk;

  cpq_tracker dut (.*);

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit w);
    @(negedge clk);
    rst_n = 0; host_sel = w; qs = 0; fetch_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1; host_sel = ~w;
    ecnt = 0; ewide = w; epend = 0; eerr = 0; evalid = 0;
    chk(q_level == 0, "R9", "level", q_level, 0);
    chk(op_valid == 0, "R9", "valid", op_valid, 0);
    chk(underflow_err == 0, "R9", "err", underflow_err, 0);
  endtask

  task automatic step(input logic [1:0] s, input bit we, input logic [15:0] d, input string tag);
    logic [7:0] b;
    int n;
    @(negedge clk);
    qs = s; fetch_we = we; fetch_data = d;
    evalid = 0;
    if (s == 2'b10) begin ecnt = 0; epend = 0; end
    else if (s[0] && ecnt == 0) eerr = 1;
    else if (s[0]) begin
      b = eq[0];
      for (int i = 0; i < 5; i++) eq[i] = eq[i+1];
      ecnt--;
      if (s == 2'b01) begin epend = (b[7:3] == 5'b11011); elo = b[2:0]; end
      else if (epend) begin
        epend = 0; evalid = 1;
        eop = {elo, b[5:3]}; emod = b[7:6]; ereg = b[5:3]; erm = b[2:0];
      end
    end
    n = we ? (ewide ? 2 : 1) : 0;
    if (we && ecnt + n <= (ewide ? 6 : 4)) begin
      eq[ecnt] = d[7:0];
      if (ewide) eq[ecnt+1] = d[15:8];
      ecnt += n;
    end
    @(posedge clk);
    #1;
    chk(q_level == ecnt, tag, "level", q_level, ecnt);
    if (ecnt > 0) chk(q_head == eq[0], tag, "head", q_head, eq[0]);
    chk(op_valid == evalid, tag, "valid", op_valid, evalid);
    if (evalid) begin
      chk(op_code == eop, tag, "opcode", op_code, eop);
      chk(op_mod == emod, tag, "mod", op_mod, emod);
      chk(op_reg == ereg, tag, "reg", op_reg, ereg);
      chk(op_rm == erm, tag, "rm", op_rm, erm);
    end
    chk(underflow_err == eerr, tag, "err", underflow_err, eerr);
    qs = 0; fetch_we = 0;
  endtask

  task automatic t_narrow;
    do_reset(0);
    step(0, 1, 16'h00D9, "R2");
    step(0, 1, 16'h00C1, "R2");
    step(1, 0, 0, "R4");
    step(3, 0, 0, "R6");
    step(0, 1, 16'h0011, "R2");
    step(0, 1, 16'h0022, "R2");
    step(0, 1, 16'h0033, "R1");
    step(0, 1, 16'h0044, "R1");
    step(0, 1, 16'h0055, "R3");
    step(1, 1, 16'h0066, "R4");
    step(0, 0, 0, "R4");
  endtask

  task automatic t_wide;
    do_reset(1);
    step(0, 1, 16'h2ADF, "R2");
    step(1, 1, 16'h0102, "R4");
    step(3, 0, 0, "R6");
    step(0, 1, 16'h0304, "R1");
    step(0, 1, 16'h0506, "R1");
    step(0, 1, 16'h0708, "R3");
    step(1, 1, 16'h090A, "R3");
  endtask

  task automatic t_nonesc;
    do_reset(0);
    step(0, 1, 16'h0090, "R7");
    step(0, 1, 16'h002A, "R7");
    step(1, 0, 0, "R7");
    step(3, 0, 0, "R7");
    step(0, 0, 0, "R7");
  endtask

  task automatic t_flush;
    do_reset(1);
    step(0, 1, 16'h3FD8, "R2");
    step(1, 0, 0, "R6");
    step(2, 1, 16'h1B00, "R5");
    step(3, 0, 0, "R5");
    step(2, 0, 0, "R5");
    step(0, 1, 16'h00DA, "R5");
    step(1, 0, 0, "R6");
    step(3, 0, 0, "R6");
  endtask

  task automatic t_under;
    do_reset(0);
    step(3, 0, 0, "R8");
    step(0, 1, 16'h0077, "R8");
    step(1, 0, 0, "R8");
    step(1, 0, 0, "R8");
    step(0, 0, 0, "R8");
  endtask

  initial begin
    t_narrow;
    t_wide;
    t_nonesc;
    t_flush;
    t_under;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    runs++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule